// File: doc/BRIEF.md
# Consensus Configuration Health Monitor

This block watches a population of interchangeable half-configurations that run in pairs. The population splits into two equal groups, left and right. At any time one member of each group is active. Both active members compute the same function, and the block receives their two output words on a valid/ready stream. With no reference for the correct answer, the only health evidence is whether the two words agree. Each accepted beat adds a discrepancy value to the running total of the active pair. In the default mode that value is 0 when the words match and 1 when they do not. In the alternate mode it is the number of differing bits.

After a fixed number of accepted beats the window closes and the monitor moves both evaluated members through a four-state health lifecycle. A pseudo-random draw may return one repaired member to service as refurbished. The next member of each group then becomes active in round-robin order, skipping members under repair. The block also flags every member whose last window discrepancy stands well above the population mean. The repair logic outside the block regenerates the members it finds requested.

The input stream has no back-pressure. `in_ready` is high in every cycle in which `rst` is low, and a beat is accepted when `in_valid` and `in_ready` are both high. The sender may drop `in_valid` at any time, and the block sees no beat in that cycle.

Top module: `cfg_health_mon`

## Requirements
- R1: With `ham_mode` low, each accepted beat adds 1 to the window total when `word_l` differs from `word_r` in any bit, and 0 when they are equal, however many bits differ.
- R2: With `ham_mode` high, each accepted beat adds the number of bit positions in which `word_l` and `word_r` differ.
- R3: `in_ready` equals the inverse of `rst`. A cycle with `in_valid` low adds nothing to the total and does not advance the window, whatever the words carry.
- R4: A window is WIN_LEN accepted beats. The beat that completes it updates the health of the active left member and the active right member, both with the same window total. Health and the active indices change only on that beat, and the next window starts from a zero total.
- R5: Health codes on `health[2k+1:2k]` for member k (left members are 0..HALF-1, right members are HALF..POP-1) are 0 pristine, 1 suspect, 2 under repair and 3 refurbished. A pristine or refurbished member whose window total exceeds SUS_TH but not REP_TH becomes suspect. A suspect member stays suspect after a window at or below REP_TH. A window at or below SUS_TH leaves the state unchanged.
- R6: A window total above REP_TH puts the member under repair, whatever its previous state, and `repair_req[k]` is high exactly while member k is under repair.
- R7: At each window end both groups advance their active index to the next member in increasing index order, wrapping, that is not under repair after that window's updates. `act_left` is the local index in the left group and `act_right` the local index in the right group.
- R8: At each window end, if the 16-bit pseudo-random value is at most `reint_thresh`, the lowest-numbered member already under repair becomes refurbished. A threshold of 0 never reintroduces and a threshold of 16'hFFFF always does. At most one member is reintroduced per window.
- R9: `outlier[k]` is high when member k's last recorded window total exceeds the mean of all POP recorded totals by more than OUT_MARGIN. Members never evaluated since reset count as 0.
- R10: A synchronous reset returns every member to pristine, sets both active indices to 0, clears all window totals and clears every `repair_req` and `outlier` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Compare beat present |
| in_ready | output | 1 | Beat can be taken (high whenever out of reset) |
| word_l | input | WORD_W | Output word of the active left member |
| word_r | input | WORD_W | Output word of the active right member |
| ham_mode | input | 1 | 0: count mismatching beats, 1: count differing bits |
| reint_thresh | input | 16 | Reintroduction threshold for the pseudo-random draw |
| act_left | output | IW | Local index of the active left member |
| act_right | output | IW | Local index of the active right member |
| health | output | 2*POP | Two-bit health code per member |
| repair_req | output | POP | Regeneration request per member |
| outlier | output | POP | Member well above the population mean |

## Verification
The bench applies full windows that differ only in how many beats mismatch and how wide the mismatch is. Single-bit and full-word mismatches in count mode show that the count ignores mismatch width, and nibble and full-word mismatches in bit-count mode show that it measures it. Totals placed just at and just past each threshold separate the pristine, suspect and repair outcomes. Idle cycles with disagreeing words show that only accepted beats count. Long sequences of windows walk the round-robin across the wrap point and past members under repair. A window held one beat short of its length shows that nothing moves before the window closes. Thresholds of 0 and all-ones make reintroduction deterministic.

// File: rtl/chm_pkg.sv
package chm_pkg;

  typedef enum logic [1:0] {
    H_PRISTINE = 2'd0,
    H_SUSPECT  = 2'd1,
    H_REPAIR   = 2'd2,
    H_REFURB   = 2'd3
  } health_t;

  // Lifecycle step for one member after one closed window.
  function automatic health_t next_health(health_t cur, int unsigned dv,
                                          int unsigned sus_th, int unsigned rep_th);
    health_t nh;
    nh = cur;
    if (dv > rep_th)
      nh = H_REPAIR;
    else if (dv > sus_th && (cur == H_PRISTINE || cur == H_REFURB))
      nh = H_SUSPECT;
    return nh;
  endfunction

endpackage

// File: rtl/chm_discrep.sv
module chm_discrep #(
  parameter int WORD_W = 8,
  localparam int DCW = $clog2(WORD_W + 1)
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic              ham,
  output logic [DCW-1:0]    d
);
  logic [WORD_W-1:0] diff;
  assign diff = a ^ b;

  always_comb begin
    if (ham) begin
      d = '0;
      for (int i = 0; i < WORD_W; i++) d = d + DCW'(diff[i]);
    end else begin
      d = DCW'(|diff);
    end
  end
endmodule

// File: rtl/chm_rr_pick.sv
module chm_rr_pick #(
  parameter int N = 10,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [IW-1:0] cur,
  input  logic [N-1:0]  blocked,
  output logic [IW-1:0] nxt
);
  always_comb begin
    logic found;
    int   c;
    nxt   = cur;
    found = 1'b0;
    for (int off = 1; off <= N; off++) begin
      c = (int'(cur) + off) % N;
      if (!found && !blocked[c]) begin
        nxt   = IW'(c);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/chm_lfsr16.sv
module chm_lfsr16 #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst,
  output logic [15:0] q
);
  logic fb;
  assign fb = q[15] ^ q[13] ^ q[12] ^ q[10];

  always_ff @(posedge clk) begin
    if (rst) q <= SEED;
    else     q <= {q[14:0], fb};
  end

  a_r8_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst) q != 16'h0)
    else $error("lfsr reached zero");
endmodule

// File: rtl/cfg_health_mon.sv
module cfg_health_mon
  import chm_pkg::*;
#(
  parameter int POP        = 20,
  parameter int WORD_W     = 8,
  parameter int WIN_LEN    = 600,
  parameter int SUS_TH     = 6,
  parameter int REP_TH     = 12,
  parameter int OUT_MARGIN = 3,
  localparam int HALF = POP / 2,
  localparam int IW   = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD_W-1:0]   word_l,
  input  logic [WORD_W-1:0]   word_r,
  input  logic                ham_mode,
  input  logic [15:0]         reint_thresh,
  output logic [IW-1:0]       act_left,
  output logic [IW-1:0]       act_right,
  output logic [2*POP-1:0]    health,
  output logic [POP-1:0]      repair_req,
  output logic [POP-1:0]      outlier
);
  localparam int DCW = $clog2(WORD_W + 1);
  localparam int DW  = $clog2(WIN_LEN * WORD_W + 1);
  localparam int CW  = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam int PW  = $clog2(POP);
  localparam int SW  = DW + $clog2(POP) + 2;

  health_t         st   [POP];
  health_t         st_n [POP];
  logic [DW-1:0]   dv_last [POP];
  logic [DW-1:0]   acc;
  logic [DW-1:0]   dv_end;
  logic [CW-1:0]   wcnt;
  logic [DCW-1:0]  d;
  logic [15:0]     rnd;
  logic            fire, last, reint_hit;
  logic [PW-1:0]   gl, gr;
  logic [HALF-1:0] blk_l, blk_r;
  logic [IW-1:0]   nxt_l, nxt_r;
  logic [SW-1:0]   dv_sum;

  assign in_ready = !rst;
  assign fire     = in_valid && in_ready;
  assign last     = fire && (wcnt == CW'(WIN_LEN - 1));
  assign dv_end   = acc + DW'(d);
  assign gl       = PW'(act_left);
  assign gr       = PW'(HALF) + PW'(act_right);

  chm_discrep #(.WORD_W(WORD_W)) u_disc (
    .a(word_l), .b(word_r), .ham(ham_mode), .d(d)
  );

  chm_lfsr16 u_lfsr (.clk(clk), .rst(rst), .q(rnd));

  // Next health of the whole population for a closing window.
  always_comb begin
    st_n      = st;
    reint_hit = 1'b0;
    if (last) begin
      st_n[gl] = next_health(st[gl], 32'(dv_end), SUS_TH, REP_TH);
      st_n[gr] = next_health(st[gr], 32'(dv_end), SUS_TH, REP_TH);
      if (rnd <= reint_thresh) begin
        for (int k = 0; k < POP; k++) begin
          if (!reint_hit && st[k] == H_REPAIR) begin
            st_n[k]   = H_REFURB;
            reint_hit = 1'b1;
          end
        end
      end
    end
  end

  for (genvar i = 0; i < HALF; i++) begin : g_blk
    assign blk_l[i] = (st_n[i] == H_REPAIR);
    assign blk_r[i] = (st_n[HALF+i] == H_REPAIR);
  end

  chm_rr_pick #(.N(HALF)) u_pick_l (.cur(act_left),  .blocked(blk_l), .nxt(nxt_l));
  chm_rr_pick #(.N(HALF)) u_pick_r (.cur(act_right), .blocked(blk_r), .nxt(nxt_r));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      wcnt      <= '0;
      act_left  <= '0;
      act_right <= '0;
      for (int k = 0; k < POP; k++) begin
        st[k]      <= H_PRISTINE;
        dv_last[k] <= '0;
      end
    end else if (last) begin
      acc         <= '0;
      wcnt        <= '0;
      act_left    <= nxt_l;
      act_right   <= nxt_r;
      dv_last[gl] <= dv_end;
      dv_last[gr] <= dv_end;
      for (int k = 0; k < POP; k++) st[k] <= st_n[k];
    end else if (fire) begin
      acc  <= dv_end;
      wcnt <= wcnt + 1'b1;
    end
  end

  // Population mean comparison without division: dv*POP > sum + margin*POP.
  always_comb begin
    dv_sum = '0;
    for (int k = 0; k < POP; k++) dv_sum = dv_sum + SW'(dv_last[k]);
  end

  for (genvar k = 0; k < POP; k++) begin : g_out
    assign health[2*k +: 2] = st[k];
    assign repair_req[k]    = (st[k] == H_REPAIR);
    assign outlier[k]       = (SW'(dv_last[k]) * SW'(POP)) > (dv_sum + SW'(OUT_MARGIN * POP));
  end

  // ---------------- assertions ----------------
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(acc) && $stable(wcnt))
    else $error("total moved without an accepted beat");

  a_r4_index_hold: assert property (@(posedge clk) disable iff (rst)
    !last |=> $stable(act_left) && $stable(act_right))
    else $error("active index moved inside a window");

  a_r6_repair_entry: assert property (@(posedge clk) disable iff (rst)
    (last && 32'(dv_end) > REP_TH && st[gl] != H_REPAIR) |=> st[$past(gl)] == H_REPAIR)
    else $error("excess total did not force repair");

  a_r7_skip_repair: assert property (@(posedge clk) disable iff (rst)
    (last && !(&blk_l)) |=> st[PW'(act_left)] != H_REPAIR)
    else $error("rotation landed on a member under repair");

  a_r8_single_reint: assert property (@(posedge clk) disable iff (rst)
    $countones($past(repair_req) & ~repair_req) <= 1)
    else $error("more than one member left repair");

endmodule

// File: tb/cfg_health_mon_bench.sv
`timescale 1ns/1ps
module cfg_health_mon_bench;
  localparam int POP  = 20;
  localparam int HALF = 10;
  localparam int WIN  = 600;
  localparam int NV   = 14;

  // Window table: mismatching beats, xor pattern, mode, expected next index, expected pair state.
  localparam int V_NMIS [NV] = '{0, 6, 7, 2, 13, 2, 3, 0, 0, 0, 0, 0, 13, 0};
  localparam int V_XOR  [NV] = '{1, 1, 1, 15, 1, 255, 255, 1, 1, 1, 1, 1, 1, 1};
  localparam int V_HAM  [NV] = '{0, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0};
  localparam int V_NEXT [NV] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 0, 1, 2, 3, 6};
  localparam int V_ST   [NV] = '{0, 0, 1, 1, 2, 2, 0, 0, 0, 0, 0, 0, 2, 1};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  word_l = '0, word_r = '0;
  logic        ham_mode = 1'b0;
  logic [15:0] reint_thresh = '0;
  logic [3:0]  act_left, act_right;
  logic [39:0] health;
  logic [19:0] repair_req, outlier;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfg_health_mon u_cfg_health_mon (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .word_l(word_l), .word_r(word_r), .ham_mode(ham_mode),
    .reint_thresh(reint_thresh), .act_left(act_left), .act_right(act_right),
    .health(health), .repair_req(repair_req), .outlier(outlier)
  );

  function automatic int st_of(int k);
    return int'(health[2*k +: 2]);
  endfunction

  task automatic check(bit ok, string req, string what, int actual, int expected);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  task automatic beats(int n, int nmis, int xv, int ham);
    ham_mode = ham[0];
    for (int b = 0; b < n; b++) begin
      if (b % 97 == 50) begin   // R3: idle cycle with disagreeing words
        @(negedge clk);
        in_valid = 1'b0; word_l = 8'hAA; word_r = 8'h55;
      end
      @(negedge clk);
      in_valid = 1'b1;
      word_l   = b[7:0];
      word_r   = (b < nmis) ? (b[7:0] ^ xv[7:0]) : b[7:0];
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b0, "R3", "ready during reset", int'(in_ready), 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int a;
    do_reset();
    // R10 reset state
    check(in_ready == 1'b1, "R3", "ready after reset", int'(in_ready), 1);
    check(act_left == 0 && act_right == 0, "R10", "index after reset", int'(act_left), 0);
    check(health == '0, "R10", "health after reset", int'(health[31:0]), 0);
    check(repair_req == '0 && outlier == '0, "R10", "flags after reset", int'(repair_req), 0);

    // Table walk: R1 R2 R4 R5 R6 R7
    a = 0;
    for (int v = 0; v < NV; v++) begin
      beats(WIN, V_NMIS[v], V_XOR[v], V_HAM[v]);
      check(st_of(a) == V_ST[v], "R5", $sformatf("left state w%0d", v), st_of(a), V_ST[v]);
      check(st_of(HALF + a) == V_ST[v], "R6", $sformatf("right state w%0d", v),
            st_of(HALF + a), V_ST[v]);
      check(int'(act_left) == V_NEXT[v] && int'(act_right) == V_NEXT[v], "R7",
            $sformatf("next index w%0d", v), int'(act_left), V_NEXT[v]);
      if (v == 5)  // R9: mean of recorded totals is 5, so totals above 8 are outliers
        check(outlier == 20'h0C030, "R9", "outlier mask", int'(outlier), 32'h0C030);
      a = V_NEXT[v];
    end
    // R8: threshold 0 kept every repaired member under repair
    check(repair_req == 20'h0D034, "R8", "repair mask, no reintroduction",
          int'(repair_req), 32'h0D034);

    // R8: all-ones threshold reintroduces the lowest repaired member (2)
    reint_thresh = 16'hFFFF;
    beats(WIN, 0, 1, 0);
    check(st_of(2) == 3, "R8", "member 2 refurbished", st_of(2), 3);
    check(repair_req == 20'h0D030, "R8", "one member left repair", int'(repair_req), 32'h0D030);
    check(st_of(6) == 0 && int'(act_left) == 7, "R7", "rotation after reintro", int'(act_left), 7);

    // R5: refurbished member with excess total becomes suspect. Walk to index 2.
    reint_thresh = 16'h0000;
    beats(WIN, 0, 1, 0);  // 7 -> 8
    beats(WIN, 0, 1, 0);  // 8 -> 9
    beats(WIN, 0, 1, 0);  // 9 -> 0
    beats(WIN, 0, 1, 0);  // 0 -> 1
    beats(WIN, 0, 1, 0);  // 1 -> 2 (refurbished, now eligible)
    check(int'(act_left) == 2, "R7", "refurbished member eligible", int'(act_left), 2);
    check(int'(act_right) == 3, "R7", "right group skips repaired 12", int'(act_right), 3);
    beats(WIN, 8, 1, 0);
    check(st_of(2) == 1, "R5", "refurbished to suspect", st_of(2), 1);

    // R10 mid-run reset
    do_reset();
    check(health == '0 && repair_req == '0 && outlier == '0, "R10", "state cleared",
          int'(repair_req), 0);
    check(act_left == 0 && act_right == 0, "R10", "index cleared", int'(act_left), 0);

    // R4 boundary: one beat short of the window changes nothing
    beats(WIN - 1, WIN, 1, 0);
    check(act_left == 0 && st_of(0) == 0, "R4", "no change before window end", int'(act_left), 0);
    beats(1, 1, 1, 0);
    check(act_left == 1 && act_right == 1, "R4", "rotation at window end", int'(act_left), 1);
    check(st_of(0) == 2 && st_of(HALF) == 2, "R4", "pair updated together", st_of(HALF), 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule